// File: doc/BRIEF.md
# Protection-Region Register Access Port

This block is the software-facing register file of a memory protection unit whose number of regions is set by a parameter (0 to 16). Each security state has its own copy of everything: a region selector, a 3-bit control word, two 32-bit attribute-indirection words, and a base and a limit word for each region. The address-matching logic that uses these values is not part of this block.

Base and limit words are reached through four address pairs. Pair 0 uses the stored region selector as it is. Pairs 1 to 3 replace the low two bits of the selector with the pair's own index. Software can therefore program four neighbouring regions without writing the selector again. If the resulting region lies outside the implemented count, the access reads zero and a write has no effect. Every accepted write that changes protection state raises a one-cycle invalidate pulse, which tells downstream translation caches to flush.

The bus is a single-cycle request port. Writes take effect at the clock edge that samples them. Read data is registered and appears in the following cycle.

Top module: `mpu_alias_port`

## Requirements
- R1: After reset every stored word (selector, control, attribute, base, limit) in both banks reads 0, `rdata_o` is 0 and `inval_o` is low.
- R2: The selector at offset 0xd98 has one copy per bank, chosen by `secure_i`, and reads back in bits [3:0]. A write whose value is at or above the region count is ignored.
- R3: The control word at offset 0xd94 has one copy per bank and keeps only bits [2:0]: bit 0 enables the unit, bit 1 keeps it active during hard-fault and NMI handling, and bit 2 turns on the privileged default map. All other bits read 0.
- R4: Base words sit at 0xd9c + 8·k and limit words at 0xda0 + 8·k, with pair index k in 0..3. For k = 0 the target region is the selector. For k ≠ 0 the target region is the selector with bits [1:0] replaced by k.
- R5: When the target region is at or above the region count, a read returns 0, and a write changes nothing and raises no invalidate.
- R6: A base or limit write to a valid region changes only that word in the bank given by `secure_i`. It never changes the selector.
- R7: The attribute words at 0xdc0 and 0xdc4 have one full 32-bit copy per bank. With a region count of 0 they read 0 and writes are dropped.
- R8: `inval_o` is high for exactly the one cycle after an accepted write to the control word or to an in-range base or limit word. It stays low after any other access.
- R9: Any offset not listed above reads 0, and a write to it changes no state.
- R10: `rdata_o` takes the addressed value at the edge that samples a read request. It keeps its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| secure_i | input | 1 | Bank select: 1 = secure copy, 0 = non-secure copy |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| inval_o | output | 1 | One-cycle translation-invalidate pulse |

## Verification
Two functions meet in a single access: the pair index substituting the low selector bits, and the range guard judging the region that substitution produces. The bench provokes this with a configuration of six regions. In that configuration a selector of 4 or 5, combined with pairs 2 and 3, lands on regions 6 and 7, which do not exist. Each such write must leave `inval_o` low and every stored word unchanged, and each such read must return zero. An arithmetic model of the substitution predicts every one of these outcomes across both banks and all four pairs.

// File: rtl/mpu_alias_pkg.sv
package mpu_alias_pkg;
  localparam int unsigned MAX_REGIONS  = 16;
  localparam int unsigned IDX_W        = 4;
  localparam int unsigned CTRL_W       = 3;
  localparam int unsigned ADDR_W       = 12;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned NUM_ALIAS    = 4;
  localparam int unsigned ALIAS_STRIDE = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'hd94;
  localparam logic [ADDR_W-1:0] OFS_SEL    = 12'hd98;
  localparam logic [ADDR_W-1:0] OFS_BASE0  = 12'hd9c;
  localparam logic [ADDR_W-1:0] OFS_LIMIT0 = 12'hda0;
  localparam logic [ADDR_W-1:0] OFS_ATTR0  = 12'hdc0;
  localparam logic [ADDR_W-1:0] OFS_ATTR1  = 12'hdc4;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_SEL,
    ACC_BASE,
    ACC_LIMIT,
    ACC_ATTR0,
    ACC_ATTR1
  } acc_kind_e;
endpackage

// File: rtl/mpu_alias_decode.sv
module mpu_alias_decode
  import mpu_alias_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [1:0]        alias_o
);
  always_comb begin
    kind_o  = ACC_NONE;
    alias_o = '0;
    unique case (addr_i)
      OFS_CTRL:  kind_o = ACC_CTRL;
      OFS_SEL:   kind_o = ACC_SEL;
      OFS_ATTR0: kind_o = ACC_ATTR0;
      OFS_ATTR1: kind_o = ACC_ATTR1;
      default:   kind_o = ACC_NONE;
    endcase
    for (int k = 0; k < int'(NUM_ALIAS); k++) begin
      if (addr_i == OFS_BASE0 + ADDR_W'(k * ALIAS_STRIDE)) begin
        kind_o  = ACC_BASE;
        alias_o = 2'(k);
      end
      if (addr_i == OFS_LIMIT0 + ADDR_W'(k * ALIAS_STRIDE)) begin
        kind_o  = ACC_LIMIT;
        alias_o = 2'(k);
      end
    end
  end
endmodule

// File: rtl/mpu_region_sel.sv
module mpu_region_sel
  import mpu_alias_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic [IDX_W-1:0] sel_i,
  input  logic [1:0]       alias_i,
  output logic [IDX_W-1:0] eff_o,
  output logic             hit_o
);
  localparam int unsigned CNT_W = IDX_W + 1;

  // pair index overrides the low two selector bits
  assign eff_o = (alias_i == 2'd0) ? sel_i : {sel_i[IDX_W-1:2], alias_i};
  assign hit_o = ({1'b0, eff_o} < CNT_W'(NUM_REGIONS));
endmodule

// File: rtl/mpu_region_store.sv
module mpu_region_store
  import mpu_alias_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              bank_i,
  input  logic              lim_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] base_q [DEPTH];
    logic [DATA_W-1:0] lim_q  [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(DEPTH); i++) begin
          base_q[i] <= '0;
          lim_q[i]  <= '0;
        end
      end else if (we_i && (bank_i == 1'(b))) begin
        if (lim_i) lim_q[idx_i]  <= wdata_i;
        else       base_q[idx_i] <= wdata_i;
      end
    end

    assign bank_rd[b] = lim_i ? lim_q[idx_i] : base_q[idx_i];
  end

  assign rdata_o = bank_rd[bank_i];
endmodule

// File: rtl/mpu_alias_port.sv
module mpu_alias_port
  import mpu_alias_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              secure_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              inval_o
);
  localparam int unsigned DEPTH   = (NUM_REGIONS > 0) ? NUM_REGIONS : 1;
  localparam int unsigned CNT_W   = IDX_W + 1;
  localparam int unsigned SEL_LIM = (NUM_REGIONS > 0) ? NUM_REGIONS : 1;

  acc_kind_e         kind;
  logic [1:0]        alias_idx;
  logic [IDX_W-1:0]  eff;
  logic              hit;
  logic [DATA_W-1:0] store_rd;
  logic [DATA_W-1:0] rd_val;
  logic              wr, rd, is_region, store_we, inval_d;

  logic [IDX_W-1:0]  sel_q  [2];
  logic [CTRL_W-1:0] ctrl_q [2];
  logic [DATA_W-1:0] attr_q [2][2];
  logic [DATA_W-1:0] rdata_q;
  logic              inval_q;

  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign is_region = (kind == ACC_BASE) || (kind == ACC_LIMIT);
  assign store_we  = wr & is_region & hit;
  assign inval_d   = wr & ((kind == ACC_CTRL) | (is_region & hit));

  mpu_alias_decode u_decode (
    .addr_i  (addr_i),
    .kind_o  (kind),
    .alias_o (alias_idx)
  );

  mpu_region_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
    .sel_i   (sel_q[secure_i]),
    .alias_i (alias_idx),
    .eff_o   (eff),
    .hit_o   (hit)
  );

  mpu_region_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (store_we),
    .bank_i  (secure_i),
    .lim_i   (kind == ACC_LIMIT),
    .idx_i   (eff),
    .wdata_i (wdata_i),
    .rdata_o (store_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++) begin
        sel_q[b]  <= '0;
        ctrl_q[b] <= '0;
      end
    end else if (wr) begin
      if (kind == ACC_SEL && wdata_i < DATA_W'(NUM_REGIONS))
        sel_q[secure_i] <= wdata_i[IDX_W-1:0];
      if (kind == ACC_CTRL)
        ctrl_q[secure_i] <= wdata_i[CTRL_W-1:0];
    end
  end

  if (NUM_REGIONS > 0) begin : g_attr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int b = 0; b < 2; b++) begin
          attr_q[b][0] <= '0;
          attr_q[b][1] <= '0;
        end
      end else if (wr) begin
        if (kind == ACC_ATTR0) attr_q[secure_i][0] <= wdata_i;
        if (kind == ACC_ATTR1) attr_q[secure_i][1] <= wdata_i;
      end
    end
  end else begin : g_no_attr
    always_comb begin
      for (int b = 0; b < 2; b++) begin
        attr_q[b][0] = '0;
        attr_q[b][1] = '0;
      end
    end
  end

  always_comb begin
    unique case (kind)
      ACC_CTRL:  rd_val = DATA_W'(ctrl_q[secure_i]);
      ACC_SEL:   rd_val = DATA_W'(sel_q[secure_i]);
      ACC_BASE,
      ACC_LIMIT: rd_val = hit ? store_rd : '0;
      ACC_ATTR0: rd_val = attr_q[secure_i][0];
      ACC_ATTR1: rd_val = attr_q[secure_i][1];
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      inval_q <= 1'b0;
    end else begin
      inval_q <= inval_d;
      if (rd) rdata_q <= rd_val;
    end
  end

  assign rdata_o = rdata_q;
  assign inval_o = inval_q;

  // R2
  sel_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, sel_q[0]} < CNT_W'(SEL_LIM)) && ({1'b0, sel_q[1]} < CNT_W'(SEL_LIM)));

  // R6
  region_wr_keeps_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && is_region) |=> ($stable(sel_q[0]) && $stable(sel_q[1])));

  // R5
  miss_no_inval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && is_region && !hit) |=> !inval_o);

  // R8
  inval_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |-> $past(wr));

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));

  // R3
  ctrl_on_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && kind == ACC_CTRL) |=> ($stable(ctrl_q[0]) && $stable(ctrl_q[1])));
endmodule

// File: tb/mpu_alias_port_bench.sv
`timescale 1ns/1ps
module mpu_alias_port_bench;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sec = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_e;
  logic        inval, inval_e;

  int tests = 0, fails = 0;

  logic [31:0] base_m [2][16];
  logic [31:0] lim_m  [2][16];
  int          sel_m  [2];

  always #2 clk = ~clk;

  mpu_alias_port #(.NUM_REGIONS(N)) u_mpu_alias_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .secure_i(sec),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .inval_o(inval)
  );

  mpu_alias_port #(.NUM_REGIONS(0)) u_mpu_alias_port_empty (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .secure_i(sec),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_e), .inval_o(inval_e)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic s, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; sec = s; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  function automatic int eff_of(input int sel, input int k);
    return (k == 0) ? sel : ((sel & 12) | k);
  endfunction

  function automatic logic [11:0] reg_addr(input int k, input int lim);
    return (lim != 0 ? 12'hda0 : 12'hd9c) + 12'(8 * k);
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      sel_m[s] = 0;
      for (int r = 0; r < 16; r++) begin
        base_m[s][r] = '0;
        lim_m[s][r]  = '0;
      end
    end
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 inval", {31'h0, inval}, 32'h0);
    rst_n = 1'b1;

    // R1: every register of both banks reads zero
    for (int s = 0; s < 2; s++) begin
      bus(0, s[0], 12'hd94, 0); chk("R1 ctrl", rdata, 0);
      bus(0, s[0], 12'hd98, 0); chk("R1 sel", rdata, 0);
      bus(0, s[0], 12'hdc0, 0); chk("R1 attr0", rdata, 0);
      bus(0, s[0], 12'hdc4, 0); chk("R1 attr1", rdata, 0);
      for (int k = 0; k < 4; k++)
        for (int l = 0; l < 2; l++) begin
          bus(0, s[0], reg_addr(k, l), 0); chk("R1 region", rdata, 0);
        end
    end

    // R2: selector banked, out-of-count writes ignored
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 16; v++) begin
        bus(1, s[0], 12'hd98, 32'(v));
        chk("R8 sel write no inval", {31'h0, inval}, 0);
        if (v < N) sel_m[s] = v;
        bus(0, s[0], 12'hd98, 0);
        chk("R2 sel readback", rdata, 32'(sel_m[s]));
        bus(0, ~s[0], 12'hd98, 0);
        chk("R2 other bank", rdata, 32'(sel_m[1-s]));
      end
    bus(1, 1'b0, 12'hd98, 32'h0000_0103);
    chk("R2 wide value ignored", 32'(sel_m[0]), 32'(sel_m[0]));
    bus(0, 1'b0, 12'hd98, 0);
    chk("R2 wide value ignored", rdata, 32'(sel_m[0]));

    // R4/R5/R6/R8: write sweep over banks, selectors, pairs, base/limit
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < N; r++) begin
        bus(1, s[0], 12'hd98, 32'(r));
        sel_m[s] = r;
        for (int k = 0; k < 4; k++)
          for (int l = 0; l < 2; l++) begin
            int e;
            logic [31:0] pat;
            e = eff_of(r, k);
            pat = 32'hA500_0000 ^ 32'(s << 20) ^ 32'(r << 12) ^ 32'(k << 8) ^ 32'(l << 4) ^ 32'(e);
            bus(1, s[0], reg_addr(k, l), pat);
            chk(e < N ? "R8 inval on region write" : "R5 no inval on miss",
                {31'h0, inval}, {31'h0, e < N});
            if (e < N) begin
              if (l != 0) lim_m[s][e] = pat; else base_m[s][e] = pat;
            end
          end
        bus(0, s[0], 12'hd98, 0);
        chk("R6 sel unchanged", rdata, 32'(r));
      end

    // R4/R5/R6: readback through every pair
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < N; r++) begin
        bus(1, s[0], 12'hd98, 32'(r));
        for (int k = 0; k < 4; k++)
          for (int l = 0; l < 2; l++) begin
            int e;
            logic [31:0] exp;
            e = eff_of(r, k);
            exp = (e >= N) ? 32'h0 : (l != 0 ? lim_m[s][e] : base_m[s][e]);
            bus(0, s[0], reg_addr(k, l), 0);
            chk(e < N ? "R4 pair readback" : "R5 miss reads zero", rdata, exp);
          end
      end

    // R3: control keeps three bits, banked, pulses invalidate
    bus(1, 1'b0, 12'hd94, 32'hFFFF_FFFF);
    chk("R8 ctrl inval", {31'h0, inval}, 1);
    bus(0, 1'b0, 12'hd94, 0); chk("R3 ctrl masked", rdata, 32'h7);
    chk("R8 single pulse", {31'h0, inval}, 0);
    bus(0, 1'b1, 12'hd94, 0); chk("R3 ctrl banked", rdata, 32'h0);
    bus(1, 1'b1, 12'hd94, 32'h0000_00F5);
    bus(0, 1'b1, 12'hd94, 0); chk("R3 ctrl secure", rdata, 32'h5);
    bus(0, 1'b0, 12'hd94, 0); chk("R3 ctrl other bank", rdata, 32'h7);

    // R7: attribute words
    bus(1, 1'b0, 12'hdc0, 32'h1234_5678);
    chk("R8 attr no inval", {31'h0, inval}, 0);
    bus(1, 1'b1, 12'hdc4, 32'hCAFE_F00D);
    bus(0, 1'b0, 12'hdc0, 0); chk("R7 attr0", rdata, 32'h1234_5678);
    chk("R7 empty attr0", rdata_e, 0);
    bus(0, 1'b1, 12'hdc0, 0); chk("R7 attr0 banked", rdata, 0);
    bus(0, 1'b1, 12'hdc4, 0); chk("R7 attr1", rdata, 32'hCAFE_F00D);
    chk("R7 empty attr1", rdata_e, 0);
    bus(0, 1'b0, 12'hdc4, 0); chk("R7 attr1 banked", rdata, 0);

    // R5: zero-region instance never hits
    bus(1, 1'b0, 12'hd9c, 32'hDEAD_BEEF);
    chk("R5 empty no inval", {31'h0, inval_e}, 0);
    bus(0, 1'b0, 12'hd9c, 0);
    chk("R5 empty reads zero", rdata_e, 0);
    bus(1, 1'b0, 12'hd98, 32'h0);

    // R9: unmapped offsets
    bus(1, 1'b0, 12'hd90, 32'hFFFF_FFFF);
    chk("R9 unmapped no inval", {31'h0, inval}, 0);
    bus(0, 1'b0, 12'hd90, 0); chk("R9 unmapped read", rdata, 0);
    bus(1, 1'b0, 12'hdbc, 32'h5555_5555);
    bus(0, 1'b0, 12'hd9c, 0); chk("R9 region untouched", rdata, base_m[0][0]);

    // R10: rdata held across writes and idle
    bus(0, 1'b0, 12'hdc0, 0);
    bus(1, 1'b0, 12'hd94, 32'h0);
    chk("R10 hold through write", rdata, 32'h1234_5678);
    repeat (3) @(negedge clk);
    chk("R10 hold idle", rdata, 32'h1234_5678);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule